// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a memory-mapped host a path into the 16-bit internal control-register space of a PHY without mapping that space directly. The host sees a small window of word registers: an input word, an output word and four command registers. Software loads the input word with a PHY register address and issues the capture-address command. For a write it then loads the value, issues capture-data, and finally issues the write command. For a read it issues the read command after capturing the address and then fetches the result from the output word. PHY control addresses sit around 0x1000 (for example 0x1002, 0x1006, 0x1010, 0x102D), but the bridge passes any 16-bit value.

Each command becomes one request/acknowledge transaction on the PHY side, tagged with a 2-bit opcode. The command bit reads back as 1 for the whole time the transaction is open, so software can poll it until it reads 0. Only one command can be open at a time. A command issued while another is still open is dropped and a sticky error output is raised.

Top module: `phy_creg_bridge`

## Requirements
- R1: After reset, every host register reads zero, `phy_req` is low and `cmd_err` is low.
- R2: The input word at byte offset 0x3C is an ordinary read/write register holding bits [15:0] of the written value; its upper read bits are zero.
- R3: With no command open, a host write with bit 0 set to offset 0x44, 0x48, 0x4C or 0x50 sets that command bit (it reads back as 1 in bit 0) and, from the next cycle, raises `phy_req` with `phy_op` equal to 0, 1, 2 or 3 respectively and `phy_wdata` equal to the input word as it stood when the command was issued.
- R4: While `phy_req` is high and `phy_ack` is low, `phy_req`, `phy_op` and `phy_wdata` hold their values, even if the input word is rewritten.
- R5: `phy_ack` sampled high at a clock edge with `phy_req` high closes the transaction: from the next cycle the command bit reads 0 and `phy_req` is low.
- R6: When a read transaction (opcode 2) closes, `phy_rdata` is latched into the output word at offset 0x40; the output word keeps its value across every other transaction.
- R7: A command write while any command bit is set, including the cycle that acknowledges it, is discarded and sets `cmd_err`, which stays high until reset; a command write with bit 0 clear has no effect and raises no error.
- R8: `phy_ack` is ignored while `phy_req` is low.
- R9: Host writes to the output word or to unmapped offsets change no register; reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W (8) | Host byte offset for reads and writes |
| host_wdata | input | HOST_W (32) | Host write data |
| host_rdata | output | HOST_W (32) | Host read data for `host_addr`, combinational |
| phy_req | output | 1 | Transaction request to the PHY |
| phy_op | output | 2 | Opcode: 0 capture address, 1 capture data, 2 read, 3 write |
| phy_wdata | output | PHY_W (16) | Word sent with the request |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | PHY_W (16) | PHY read result, valid with `phy_ack` on reads |
| cmd_err | output | 1 | Sticky flag: a command arrived while one was open |

## Verification
The bench builds the bridge with its default parameters: an 8-bit host offset, a 32-bit host word and a 16-bit PHY word, with the six register offsets at their default byte positions. These values put every mapped offset and the unmapped gaps between them within reach, and the upper half of the host word lets the bench show that only the low 16 bits reach the PHY. The tests walk a full three-step PHY write and a two-step read with variable acknowledge latency. They rewrite the input word during an open request and collide commands with an open one and with the acknowledge cycle itself.

// File: rtl/phy_creg_pkg.sv
package phy_creg_pkg;

  // Opcode on the PHY-side port; the index of a command bit equals its opcode.
  typedef enum logic [1:0] {
    OP_CAP_ADDR = 2'd0,
    OP_CAP_DATA = 2'd1,
    OP_READ     = 2'd2,
    OP_WRITE    = 2'd3
  } creg_op_e;

  localparam int unsigned NCMD   = 4;
  localparam int unsigned OP_W   = 2;
  localparam int unsigned IDX_RD = 2;

endpackage

// File: rtl/creg_rst_sync.sv
module creg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_s_n = shift_q[STAGES-1];

endmodule

// File: rtl/creg_host_regs.sv
module creg_host_regs
  import phy_creg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HOST_W = 32,
  parameter int unsigned PHY_W  = 16,
  parameter logic [ADDR_W-1:0] OFF_DIN  = 8'h3C,
  parameter logic [ADDR_W-1:0] OFF_DOUT = 8'h40,
  parameter logic [ADDR_W-1:0] OFF_CAPA = 8'h44,
  parameter logic [ADDR_W-1:0] OFF_CAPD = 8'h48,
  parameter logic [ADDR_W-1:0] OFF_RD   = 8'h4C,
  parameter logic [ADDR_W-1:0] OFF_WR   = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] rdata,
  input  logic [NCMD-1:0]   cmd_q,
  input  logic              rd_done,
  input  logic [PHY_W-1:0]  phy_rdata,
  output logic [NCMD-1:0]   cmd_hit,
  output logic [PHY_W-1:0]  din_q,
  output logic [PHY_W-1:0]  dout_q
);

  // Command offsets indexed by opcode.
  localparam logic [NCMD-1:0][ADDR_W-1:0] CMD_OFF = {OFF_WR, OFF_RD, OFF_CAPD, OFF_CAPA};

  logic             din_en;
  logic [PHY_W-1:0] din_d;
  logic             dout_en;
  logic [PHY_W-1:0] dout_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[HOST_W-1:PHY_W];

  // Command strobe decode, one per command register.
  for (genvar g = 0; g < NCMD; g++) begin : g_hit
    assign cmd_hit[g] = wr_en && (addr == CMD_OFF[g]) && wdata[0];
  end

  always_comb begin
    din_en  = wr_en && (addr == OFF_DIN);
    din_d   = wdata[PHY_W-1:0];
    dout_en = rd_done;
    dout_d  = phy_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
    end else if (din_en) begin
      din_q <= din_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  // Read-back multiplexer.
  always_comb begin
    rdata = '0;
    if (addr == OFF_DIN) begin
      rdata[PHY_W-1:0] = din_q;
    end
    if (addr == OFF_DOUT) begin
      rdata[PHY_W-1:0] = dout_q;
    end
    for (int i = 0; i < NCMD; i++) begin
      if (addr == CMD_OFF[i]) begin
        rdata[0] = cmd_q[i];
      end
    end
  end

endmodule

// File: rtl/creg_cmd_seq.sv
module creg_cmd_seq
  import phy_creg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] cmd_hit,
  input  logic            phy_ack,
  output logic [NCMD-1:0] cmd_q,
  output logic            accept,
  output logic            ack_take,
  output logic            rd_done,
  output logic            err_q
);

  logic            busy;
  logic            any_hit;
  logic [NCMD-1:0] cmd_d;
  logic            err_d;

  always_comb begin
    busy     = |cmd_q;
    any_hit  = |cmd_hit;
    ack_take = busy && phy_ack;
    accept   = !busy && any_hit;
    rd_done  = ack_take && cmd_q[IDX_RD];
    err_d    = err_q | (busy && any_hit);
  end

  // One command flop per opcode.
  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    always_comb begin
      if (ack_take) begin
        cmd_d[g] = 1'b0;
      end else if (accept) begin
        cmd_d[g] = cmd_hit[g];
      end else begin
        cmd_d[g] = cmd_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q[g] <= 1'b0;
      end else begin
        cmd_q[g] <= cmd_d[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/creg_phy_port.sv
module creg_phy_port
  import phy_creg_pkg::*;
#(
  parameter int unsigned PHY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ack_take,
  input  logic [NCMD-1:0]  cmd_hit,
  input  logic [PHY_W-1:0] din_q,
  output logic             phy_req,
  output logic [OP_W-1:0]  phy_op,
  output logic [PHY_W-1:0] phy_wdata
);

  logic             req_d;
  logic [OP_W-1:0]  op_d;
  logic             load_en;

  always_comb begin
    load_en = accept;
    op_d    = '0;
    for (int i = 0; i < NCMD; i++) begin
      if (cmd_hit[i]) begin
        op_d = OP_W'(i);
      end
    end
    if (ack_take) begin
      req_d = 1'b0;
    end else if (accept) begin
      req_d = 1'b1;
    end else begin
      req_d = phy_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_req <= 1'b0;
    end else begin
      phy_req <= req_d;
    end
  end

  // Launch copy: opcode and word frozen for the life of the request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_op    <= '0;
      phy_wdata <= '0;
    end else if (load_en) begin
      phy_op    <= op_d;
      phy_wdata <= din_q;
    end
  end

endmodule

// File: rtl/phy_creg_bridge.sv
module phy_creg_bridge
  import phy_creg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HOST_W = 32,
  parameter int unsigned PHY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              phy_req,
  output logic [OP_W-1:0]   phy_op,
  output logic [PHY_W-1:0]  phy_wdata,
  input  logic              phy_ack,
  input  logic [PHY_W-1:0]  phy_rdata,
  output logic              cmd_err
);

  logic            rst_s_n;
  logic [NCMD-1:0] cmd_hit;
  logic [NCMD-1:0] cmd_q;
  logic            accept;
  logic            ack_take;
  logic            rd_done;
  logic [PHY_W-1:0] din_q;
  logic [PHY_W-1:0] dout_q;

  creg_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  creg_host_regs #(
    .ADDR_W (ADDR_W),
    .HOST_W (HOST_W),
    .PHY_W  (PHY_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (host_wr_en),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .rdata     (host_rdata),
    .cmd_q     (cmd_q),
    .rd_done   (rd_done),
    .phy_rdata (phy_rdata),
    .cmd_hit   (cmd_hit),
    .din_q     (din_q),
    .dout_q    (dout_q)
  );

  creg_cmd_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cmd_hit  (cmd_hit),
    .phy_ack  (phy_ack),
    .cmd_q    (cmd_q),
    .accept   (accept),
    .ack_take (ack_take),
    .rd_done  (rd_done),
    .err_q    (cmd_err)
  );

  creg_phy_port #(.PHY_W(PHY_W)) port_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .accept    (accept),
    .ack_take  (ack_take),
    .cmd_hit   (cmd_hit),
    .din_q     (din_q),
    .phy_req   (phy_req),
    .phy_op    (phy_op),
    .phy_wdata (phy_wdata)
  );

endmodule

// File: rtl/creg_bridge_chk.sv
module creg_bridge_chk
  import phy_creg_pkg::*;
#(
  parameter int unsigned PHY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phy_req,
  input logic             phy_ack,
  input logic [OP_W-1:0]  phy_op,
  input logic [PHY_W-1:0] phy_wdata,
  input logic [NCMD-1:0]  cmd_q,
  input logic [NCMD-1:0]  cmd_hit,
  input logic [PHY_W-1:0] dout_q,
  input logic             cmd_err
);

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q));

  assert_req_tracks_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req == (|cmd_q));

  assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack) |=> (phy_req && $stable(phy_op) && $stable(phy_wdata)));

  assert_drop_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ack) |=> (!phy_req && (cmd_q == '0)));

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_req && phy_ack && phy_op == OP_READ) |=> $stable(dout_q));

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_q) && (|cmd_hit) && !phy_ack) |=> ($stable(cmd_q) && cmd_err));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  assert_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_req && phy_ack && (cmd_hit == '0)) |=> !phy_req);

endmodule

bind phy_creg_bridge creg_bridge_chk #(.PHY_W(PHY_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .phy_req   (phy_req),
  .phy_ack   (phy_ack),
  .phy_op    (phy_op),
  .phy_wdata (phy_wdata),
  .cmd_q     (cmd_q),
  .cmd_hit   (cmd_hit),
  .dout_q    (dout_q),
  .cmd_err   (cmd_err)
);

// File: tb/phy_creg_bridge_tb_top.sv
module phy_creg_bridge_tb_top;

  localparam int ADDR_W = 8;
  localparam int HOST_W = 32;
  localparam int PHY_W  = 16;

  localparam logic [7:0] A_DIN  = 8'h3C;
  localparam logic [7:0] A_DOUT = 8'h40;
  localparam logic [7:0] A_CAPA = 8'h44;
  localparam logic [7:0] A_CAPD = 8'h48;
  localparam logic [7:0] A_RD   = 8'h4C;
  localparam logic [7:0] A_WR   = 8'h50;

  logic              clk;
  logic              rst_n;
  logic              host_wr_en;
  logic [ADDR_W-1:0] host_addr;
  logic [HOST_W-1:0] host_wdata;
  logic [HOST_W-1:0] host_rdata;
  logic              phy_req;
  logic [1:0]        phy_op;
  logic [PHY_W-1:0]  phy_wdata;
  logic              phy_ack;
  logic [PHY_W-1:0]  phy_rdata;
  logic              cmd_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  phy_creg_bridge #(.ADDR_W(ADDR_W), .HOST_W(HOST_W), .PHY_W(PHY_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .phy_req    (phy_req),
    .phy_op     (phy_op),
    .phy_wdata  (phy_wdata),
    .phy_ack    (phy_ack),
    .phy_rdata  (phy_rdata),
    .cmd_err    (cmd_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Host write: one strobe cycle, returns at the next falling edge.
  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    host_wdata = '0;
  endtask

  // Host read: combinational, sampled mid-cycle.
  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // PHY acknowledge after a number of idle cycles; returns one cycle after ack.
  task automatic ack_after(input int waitc, input logic [15:0] rd);
    for (int i = 0; i < waitc; i++) @(negedge clk);
    phy_ack   = 1'b1;
    phy_rdata = rd;
    @(negedge clk);
    phy_ack   = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hrd(A_DIN, v);  check("R1 data-in", v, 0);
    hrd(A_DOUT, v); check("R1 data-out", v, 0);
    hrd(A_CAPA, v); check("R1 cap-addr", v, 0);
    hrd(A_CAPD, v); check("R1 cap-data", v, 0);
    hrd(A_RD, v);   check("R1 read cmd", v, 0);
    hrd(A_WR, v);   check("R1 write cmd", v, 0);
    check("R1 req", phy_req, 0);
    check("R1 err", cmd_err, 0);
  endtask

  task automatic t_datain();
    logic [31:0] v;
    hwr(A_DIN, 32'h0000_1002);
    hrd(A_DIN, v); check("R2 data-in readback", v, 32'h1002);
    hwr(A_DIN, 32'hFFFF_ABCD);
    hrd(A_DIN, v); check("R2 upper bits zero", v, 32'h0000_ABCD);
    check("R2 no request", phy_req, 0);
  endtask

  // Issue one command and verify launch; returns with request open.
  task automatic issue(input logic [7:0] a, input logic [1:0] op, input logic [15:0] word, input string req);
    logic [31:0] v;
    hwr(A_DIN, {16'hDEAD, word});
    hwr(a, 32'h1);
    hrd(a, v);
    check({req, " bit set"}, v, 1);
    check({req, " req"}, phy_req, 1);
    check({req, " op"}, phy_op, op);
    check({req, " word"}, phy_wdata, word);
  endtask

  task automatic t_write_seq();
    logic [31:0] v;
    issue(A_CAPA, 2'd0, 16'h102D, "R3 cap-addr");
    hwr(A_DIN, 32'h0000_7777);
    @(negedge clk);
    check("R4 req held", phy_req, 1);
    check("R4 word held", phy_wdata, 16'h102D);
    check("R4 op held", phy_op, 0);
    ack_after(0, 16'h0);
    hrd(A_CAPA, v);
    check("R5 cap-addr cleared", v, 0);
    check("R5 req dropped", phy_req, 0);
    issue(A_CAPD, 2'd1, 16'h0080, "R3 cap-data");
    ack_after(2, 16'h0);
    hrd(A_CAPD, v); check("R5 cap-data cleared", v, 0);
    issue(A_WR, 2'd3, 16'h0080, "R3 write");
    ack_after(5, 16'h0);
    hrd(A_WR, v); check("R5 write cleared", v, 0);
    check("R5 req low", phy_req, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    issue(A_CAPA, 2'd0, 16'h1006, "R3 read addr");
    ack_after(1, 16'h0);
    issue(A_RD, 2'd2, 16'h1006, "R3 read");
    hrd(A_DOUT, v); check("R6 data-out before ack", v, 0);
    ack_after(3, 16'h5A5A);
    hrd(A_DOUT, v); check("R6 data-out latched", v, 32'h5A5A);
    hrd(A_RD, v);   check("R5 read cleared", v, 0);
    issue(A_WR, 2'd3, 16'h0011, "R3 write after read");
    ack_after(0, 16'h1234);
    hrd(A_DOUT, v); check("R6 data-out held after write", v, 32'h5A5A);
  endtask

  task automatic t_zero_and_stray();
    logic [31:0] v;
    hwr(A_RD, 32'hFFFF_FFFE);
    check("R7 zero write no req", phy_req, 0);
    check("R7 zero write no err", cmd_err, 0);
    hrd(A_RD, v); check("R7 zero write bit", v, 0);
    phy_rdata = 16'hBEEF;
    ack_after(0, 16'hBEEF);
    hrd(A_DOUT, v); check("R8 stray ack data-out", v, 32'h5A5A);
    check("R8 stray ack req", phy_req, 0);
    check("R8 stray ack err", cmd_err, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    hwr(A_DOUT, 32'h0000_1111);
    hrd(A_DOUT, v); check("R9 data-out not writable", v, 32'h5A5A);
    hwr(8'h00, 32'hFFFF_FFFF);
    hwr(8'h54, 32'h1);
    hrd(8'h00, v); check("R9 unmapped read zero", v, 0);
    hrd(8'h54, v); check("R9 unmapped 0x54 zero", v, 0);
    check("R9 no req", phy_req, 0);
    hrd(A_DIN, v); check("R9 data-in untouched", v, 32'h0011);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    issue(A_CAPA, 2'd0, 16'h1010, "R3 busy base");
    hwr(A_WR, 32'h1);
    hrd(A_WR, v);   check("R7 second bit not set", v, 0);
    hrd(A_CAPA, v); check("R7 first bit kept", v, 1);
    check("R7 op kept", phy_op, 0);
    check("R7 err set", cmd_err, 1);
    // Collide a command with the acknowledge cycle itself.
    @(negedge clk);
    phy_ack    = 1'b1;
    host_wr_en = 1'b1;
    host_addr  = A_RD;
    host_wdata = 32'h1;
    @(negedge clk);
    phy_ack    = 1'b0;
    host_wr_en = 1'b0;
    check("R7 ack-cycle command dropped", phy_req, 0);
    hrd(A_RD, v); check("R7 ack-cycle read bit", v, 0);
    repeat (3) @(negedge clk);
    check("R7 err sticky", cmd_err, 1);
  endtask

  initial begin
    rst_n      = 1'b0;
    host_wr_en = 1'b0;
    host_addr  = '0;
    host_wdata = '0;
    phy_ack    = 1'b0;
    phy_rdata  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_datain();
    t_write_seq();
    t_read();
    t_zero_and_stray();
    t_unmapped();
    t_busy();
    done = 1;
    report();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule